// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block carries out the vector configuration instruction with an immediate type field. It receives a decoded 32-bit instruction word, the operand read from the first source register, and an issue strobe. It keeps the architectural vector length (vl) and vector type (vtype) state in its own registers. When it recognises the instruction, it unpacks element width, register grouping and the two agnostic-policy bits from the immediate. It then picks the requested length in one of three ways, depending on whether the source and destination register indices are zero. The new length is limited to the largest length the chosen configuration allows, and the result is written back.

The vector register width is a parameter. The largest legal length is VLEN × LMUL / SEW, taken as a power-of-two exponent. An illegal request sets the illegal flag in vtype, clears the other vtype bits and forces vl to zero. In the same cycle as the state update, the block presents a one-cycle write-back of the new length to the destination register. No write-back is made when the destination is register zero.

Top module: `vcfg_unit`

## Requirements
- R1: After reset, vtype reads with only its illegal flag (bit XLEN-1) set and every other bit 0, vl reads 0, and rd_we is 0.
- R2: An issued word updates state only if it has instr[6:0] = 7'h57, instr[14:12] = 3'b111 and instr[31] = 0. Any other word leaves vl, vtype and rd_we unchanged.
- R3: When the source index instr[19:15] is nonzero, the requested length is rs1_value and the new vl is min(rs1_value, VLMAX).
- R4: When the source index is zero and the destination index instr[11:7] is nonzero, the requested length is all ones, so the new vl equals VLMAX.
- R5: When both indices are zero, the current vl is kept and vtype takes the new fields, provided the new VLMAX equals the VLMAX of the current legal vtype.
- R6: When both indices are zero and the current vtype is illegal or its VLMAX differs from the new one, the result is illegal.
- R7: VLMAX = VLEN × LMUL / SEW. SEW = 8 << imm[5:3] for imm[5:3] in 0..3. LMUL = 1, 2, 4, 8 for imm[2:0] = 0..3, and 1/8, 1/4, 1/2 for imm[2:0] = 5, 6, 7. The immediate is instr[30:20].
- R8: imm[5:3] > 3, imm[2:0] = 4, SEW greater than ELEN, or any nonzero bit in imm[10:8] makes the result illegal. An illegal result sets vtype to only bit XLEN-1 and sets vl to 0.
- R9: On the cycle after an accepted instruction with a nonzero destination, rd_we is 1 for exactly one cycle, rd_addr is the destination and rd_data is the new vl. With destination zero, rd_we stays 0.
- R10: A legal result sets vtype[7:0] to imm[7:0] (imm[2:0] grouping, imm[5:3] width, bit 6 tail agnostic, bit 7 mask agnostic) and clears every other vtype bit.
- R11: A legal-looking setting whose VLMAX would be below one element (for example SEW 64 with LMUL 1/8 at VLEN 128) is illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction word is presented this cycle |
| instr | input | 32 | Instruction word |
| rs1_value | input | XLEN | Value of the first source register |
| rd_we | output | 1 | Destination write strobe |
| rd_addr | output | 5 | Destination register index |
| rd_data | output | XLEN | New length written to the destination |
| vl | output | $clog2(VLEN)+1 | Current vector length |
| vtype | output | XLEN | Current vector type, illegal flag in bit XLEN-1 |

## Verification
Every result is registered. The new vl, the new vtype and the write-back strobe with its address and data all appear at the first rising edge after an accepted issue, and they change at no other time. The bench drives inputs on falling edges. A behavioural model updates on the same rising edge that the design samples, and the bench compares model and outputs on every following falling edge. Each comparison therefore lands exactly one cycle after the stimulus, and the next stimulus is driven only after that comparison.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

   localparam logic [6:0] VCFG_OPCODE = 7'h57;
   localparam logic [2:0] VCFG_FUNCT3 = 3'b111;
   localparam int         TYPE_BITS   = 8;

   // packed so that bit 7..0 match immediate bit 7..0
   typedef struct packed {
      logic       vma;
      logic       vta;
      logic [2:0] vsew;
      logic [2:0] vlmul;
   } vtype_fields_t;

   typedef enum logic [1:0] {
      AVL_FROM_REG  = 2'd0,
      AVL_FROM_MAX  = 2'd1,
      AVL_FROM_KEEP = 2'd2
   } avl_src_e;

   function automatic int lmul_exp(input logic [2:0] code);
      return code[2] ? int'(code) - 8 : int'(code);
   endfunction

endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
   import vcfg_pkg::*;
#(
   parameter int ELEN = 64
) (
   input  logic [31:0]   instr,
   output logic          match,
   output logic [4:0]    rd_idx,
   output logic [4:0]    rs1_idx,
   output vtype_fields_t fields,
   output logic          field_bad
);
   localparam int LOG2_ELEN = $clog2(ELEN);

   logic [10:0] zimm;
   logic        sew_bad;
   logic        lmul_bad;
   logic        resv_bad;

   assign zimm    = instr[30:20];
   assign rd_idx  = instr[11:7];
   assign rs1_idx = instr[19:15];
   assign match   = (instr[6:0] == VCFG_OPCODE) && (instr[14:12] == VCFG_FUNCT3)
                    && !instr[31];

   assign fields   = vtype_fields_t'(zimm[TYPE_BITS-1:0]);
   assign sew_bad  = fields.vsew[2] || ((int'(fields.vsew) + 3) > LOG2_ELEN);
   assign lmul_bad = (fields.vlmul == 3'd4);
   assign resv_bad = |zimm[10:TYPE_BITS];
   assign field_bad = sew_bad || lmul_bad || resv_bad;

endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax
   import vcfg_pkg::*;
#(
   parameter int VLEN      = 128,
   parameter bit USE_TABLE = 1'b0,
   parameter int VL_W      = $clog2(VLEN) + 1
) (
   input  logic [2:0]      vsew,
   input  logic [2:0]      vlmul,
   output logic [VL_W-1:0] vlmax,
   output logic            empty
);
   localparam int LOG2_VLEN = $clog2(VLEN);

   generate
      if (USE_TABLE) begin : g_table
         logic [VL_W-1:0] tbl [32];
         for (genvar s = 0; s < 4; s++) begin : g_sew
            for (genvar l = 0; l < 8; l++) begin : g_lmul
               localparam int E = LOG2_VLEN + ((l >= 4) ? l - 8 : l) - (s + 3);
               if (E >= 0) begin : g_ok
                  assign tbl[s*8+l] = VL_W'(1) << E;
               end else begin : g_zero
                  assign tbl[s*8+l] = '0;
               end
            end
         end
         logic unused_sew_msb;
         assign unused_sew_msb = vsew[2];
         assign vlmax = tbl[{vsew[1:0], vlmul}];
         assign empty = (vlmax == '0);
      end else begin : g_shift
         int expo;
         always_comb begin
            expo  = LOG2_VLEN + lmul_exp(vlmul) - (int'(vsew) + 3);
            empty = (expo < 0);
            vlmax = empty ? '0 : (VL_W'(1) << expo);
         end
      end
   endgenerate

endmodule

// File: rtl/vcfg_len_sel.sv
module vcfg_len_sel
   import vcfg_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int VL_W = 8
) (
   input  logic [4:0]      rs1_idx,
   input  logic [4:0]      rd_idx,
   input  logic [XLEN-1:0] rs1_value,
   input  logic [VL_W-1:0] cur_vl,
   input  logic [VL_W-1:0] vlmax,
   output logic            keep_mode,
   output logic [VL_W-1:0] new_len
);
   avl_src_e        src;
   logic [XLEN-1:0] avl;

   always_comb begin
      if (rs1_idx != 5'd0)      src = AVL_FROM_REG;
      else if (rd_idx != 5'd0)  src = AVL_FROM_MAX;
      else                      src = AVL_FROM_KEEP;
   end

   always_comb begin
      unique case (src)
         AVL_FROM_REG:  avl = rs1_value;
         AVL_FROM_MAX:  avl = '1;
         default:       avl = XLEN'(cur_vl);
      endcase
   end

   assign keep_mode = (src == AVL_FROM_KEEP);
   assign new_len   = (avl < XLEN'(vlmax)) ? avl[VL_W-1:0] : vlmax;

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
   import vcfg_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int VLEN      = 128,
   parameter int ELEN      = 64,
   parameter bit USE_TABLE = 1'b0,
   parameter int VL_W      = $clog2(VLEN) + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            issue_valid,
   input  logic [31:0]     instr,
   input  logic [XLEN-1:0] rs1_value,
   output logic            rd_we,
   output logic [4:0]      rd_addr,
   output logic [XLEN-1:0] rd_data,
   output logic [VL_W-1:0] vl,
   output logic [XLEN-1:0] vtype
);
   generate
      if ((VLEN & (VLEN - 1)) != 0 || VLEN < 8) begin : g_bad_vlen
         $error("VLEN must be a power of two of at least 8");
      end
      if (ELEN != 32 && ELEN != 64) begin : g_bad_elen
         $error("ELEN must be 32 or 64");
      end
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("XLEN must be 32 or 64");
      end
      if (XLEN < VL_W) begin : g_bad_vlw
         $error("XLEN too narrow for the length register");
      end
   endgenerate

   logic            match, field_bad, new_empty, cur_empty, keep_mode;
   logic [4:0]      rd_idx, rs1_idx;
   vtype_fields_t   new_fields, fields_q;
   logic [VL_W-1:0] new_vlmax, cur_vlmax, new_len, vl_q;
   logic            vill_q;
   logic            fire, ratio_bad, illegal;

   vcfg_decode #(.ELEN(ELEN)) u_dec (
      .instr     (instr),
      .match     (match),
      .rd_idx    (rd_idx),
      .rs1_idx   (rs1_idx),
      .fields    (new_fields),
      .field_bad (field_bad)
   );

   vcfg_vlmax #(.VLEN(VLEN), .USE_TABLE(USE_TABLE), .VL_W(VL_W)) u_new_max (
      .vsew  (new_fields.vsew),
      .vlmul (new_fields.vlmul),
      .vlmax (new_vlmax),
      .empty (new_empty)
   );

   vcfg_vlmax #(.VLEN(VLEN), .USE_TABLE(USE_TABLE), .VL_W(VL_W)) u_cur_max (
      .vsew  (fields_q.vsew),
      .vlmul (fields_q.vlmul),
      .vlmax (cur_vlmax),
      .empty (cur_empty)
   );

   vcfg_len_sel #(.XLEN(XLEN), .VL_W(VL_W)) u_len (
      .rs1_idx   (rs1_idx),
      .rd_idx    (rd_idx),
      .rs1_value (rs1_value),
      .cur_vl    (vl_q),
      .vlmax     (new_vlmax),
      .keep_mode (keep_mode),
      .new_len   (new_len)
   );

   assign fire      = issue_valid && match;
   assign ratio_bad = keep_mode && (vill_q || cur_empty || (cur_vlmax != new_vlmax));
   assign illegal   = field_bad || new_empty || ratio_bad;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vl_q     <= '0;
         vill_q   <= 1'b1;
         fields_q <= '0;
         rd_we    <= 1'b0;
         rd_addr  <= '0;
         rd_data  <= '0;
      end else begin
         rd_we <= fire && (rd_idx != 5'd0);
         if (fire) begin
            vill_q   <= illegal;
            fields_q <= illegal ? '0 : new_fields;
            vl_q     <= illegal ? '0 : new_len;
            rd_addr  <= rd_idx;
            rd_data  <= illegal ? '0 : XLEN'(new_len);
         end
      end
   end

   assign vl    = vl_q;
   assign vtype = {vill_q, {(XLEN-1-TYPE_BITS){1'b0}}, fields_q};

   p_vill_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      vtype[XLEN-1] |-> (vl == '0 && vtype[XLEN-2:0] == '0));
   p_vl_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !vtype[XLEN-1] |-> (vl <= cur_vlmax));
   p_no_x0_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> (rd_addr != 5'd0));
   p_write_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_we |-> (rd_data == XLEN'(vl)));
   p_write_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && rd_idx != 5'd0) |=> rd_we);
   p_no_stray_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !rd_we);
   p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> ($stable(vl) && $stable(vtype)));
   p_keep_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && keep_mode && !illegal) |=> (vl == $past(vl)));
   p_ratio_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && keep_mode && (cur_vlmax != new_vlmax)) |=> vtype[XLEN-1]);
   p_field_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && field_bad) |=> vtype[XLEN-1]);

endmodule

// File: tb/tb_vcfg_unit.sv
module tb_vcfg_unit;
   localparam int XLEN = 32;
   localparam int VLEN = 128;
   localparam int VL_W = $clog2(VLEN) + 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            issue_valid = 1'b0;
   logic [31:0]     instr = '0;
   logic [XLEN-1:0] rs1_value = '0;
   logic            rd_we;
   logic [4:0]      rd_addr;
   logic [XLEN-1:0] rd_data;
   logic [VL_W-1:0] vl;
   logic [XLEN-1:0] vtype;

   vcfg_unit #(.XLEN(XLEN), .VLEN(VLEN)) dut (
      .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
      .rs1_value(rs1_value), .rd_we(rd_we), .rd_addr(rd_addr), .rd_data(rd_data),
      .vl(vl), .vtype(vtype)
   );

   always #5 clk = ~clk;

   int     n_tests = 0, n_fail = 0;
   string  tag = "R1", m_tag = "R1";
   bit     started = 0;
   longint m_vl = 0;
   bit     m_vill = 1;
   logic [7:0] m_fields = '0;
   bit     m_we = 0;
   int     m_rd = 0;
   longint m_data = 0;

   function automatic longint ref_vlmax(int sew_c, int lmul_c);
      int sew;
      if (sew_c > 3 || lmul_c == 4) return 0;
      sew = 8 << sew_c;
      if (lmul_c < 4) return VLEN * (1 << lmul_c) / sew;
      return VLEN / (sew * (1 << (8 - lmul_c)));
   endfunction

   always @(posedge clk) begin
      started <= 1;
      if (!rst_n) begin
         m_vl = 0; m_vill = 1; m_fields = '0; m_we = 0; m_tag = "R1";
      end else begin
         m_we = 0;
         if (issue_valid && instr[6:0] == 7'h57 && instr[14:12] == 3'b111 && !instr[31]) begin
            int rd_i, rs1_i;
            logic [10:0] z;
            longint avl, nmax;
            bit bad;
            rd_i = int'(instr[11:7]); rs1_i = int'(instr[19:15]); z = instr[30:20];
            nmax = ref_vlmax(int'(z[5:3]), int'(z[2:0]));
            bad = (z[10:8] != 0) || (nmax == 0);
            if (rs1_i != 0) avl = longint'(rs1_value);
            else if (rd_i != 0) avl = 64'hFFFF_FFFF;
            else begin
               avl = m_vl;
               if (m_vill || ref_vlmax(int'(m_fields[5:3]), int'(m_fields[2:0])) != nmax) bad = 1;
            end
            if (bad) begin m_vill = 1; m_fields = '0; m_vl = 0; end
            else begin
               m_vill = 0; m_fields = z[7:0]; m_vl = (avl < nmax) ? avl : nmax;
            end
            m_we = (rd_i != 0);
            if (rd_i != 0) begin m_rd = rd_i; m_data = m_vl; end
         end
         m_tag = tag;
      end
   end

   always @(negedge clk) begin
      if (started) begin
         logic [XLEN-1:0] exp_vtype;
         exp_vtype = {m_vill, {(XLEN-9){1'b0}}, m_fields};
         n_tests++;
         if (vl !== VL_W'(m_vl) || vtype !== exp_vtype) begin
            n_fail++;
            $display("FAIL %s state: vl=%0d vtype=%h expected vl=%0d vtype=%h",
                     m_tag, vl, vtype, m_vl, exp_vtype);
         end
         n_tests++;
         if (rd_we !== m_we || (m_we && (rd_addr !== 5'(m_rd) || rd_data !== XLEN'(m_data)))) begin
            n_fail++;
            $display("FAIL %s R9 write: we=%0d rd=%0d data=%0d expected we=%0d rd=%0d data=%0d",
                     m_tag, rd_we, rd_addr, rd_data, m_we, m_rd, m_data);
         end
      end
   end

   function automatic logic [31:0] enc(int rd_i, int rs1_i, logic [10:0] z);
      return {1'b0, z, 5'(rs1_i), 3'b111, 5'(rd_i), 7'h57};
   endfunction

   task automatic issue(logic [31:0] w, logic [XLEN-1:0] v, string t);
      @(negedge clk);
      instr = w; rs1_value = v; issue_valid = 1'b1; tag = t;
      @(negedge clk);
      issue_valid = 1'b0;
      @(negedge clk);
   endtask

   // immediate: bits 2:0 grouping, 5:3 width, 6 tail agnostic, 7 mask agnostic
   function automatic logic [10:0] zi(int sew_c, int lmul_c, int ta, int ma);
      return {3'b000, 1'(ma), 1'(ta), 3'(sew_c), 3'(lmul_c)};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 rejected words while illegal
      issue(enc(3, 0, zi(0, 0, 0, 0)) ^ 32'h1, 32'd5, "R2");
      issue(enc(3, 0, zi(0, 0, 0, 0)) ^ 32'h1000, 32'd5, "R2");
      // R3 register length
      issue(enc(5, 6, zi(2, 0, 1, 1)), 32'd3, "R3");
      issue(enc(5, 6, zi(2, 0, 1, 1)), 32'd100, "R3");
      issue(enc(5, 6, zi(2, 0, 0, 0)), 32'd0, "R3");
      issue(enc(0, 6, zi(2, 1, 0, 0)), 32'd7, "R9");
      // R2 rejected words with legal state
      issue(enc(3, 0, zi(0, 3, 0, 0)) | 32'h8000_0000, 32'd5, "R2");
      issue(enc(3, 0, zi(0, 3, 0, 0)) ^ 32'h0000_0020, 32'd5, "R2");
      // R4 maximum length
      issue(enc(7, 0, zi(0, 3, 0, 0)), 32'd0, "R4");
      issue(enc(7, 0, zi(1, 7, 1, 0)), 32'd0, "R7");
      issue(enc(7, 0, zi(3, 7, 0, 1)), 32'd0, "R7");
      // R5 keep length with matching ratio
      issue(enc(4, 9, zi(0, 0, 0, 0)), 32'd10, "R5");
      issue(enc(0, 0, zi(1, 1, 1, 1)), 32'd0, "R5");
      // R6 keep length with changed ratio, then from illegal
      issue(enc(0, 0, zi(2, 1, 0, 0)), 32'd0, "R6");
      issue(enc(0, 0, zi(2, 1, 0, 0)), 32'd0, "R6");
      // R10 policy bits
      issue(enc(2, 1, zi(2, 1, 1, 1)), 32'd6, "R10");
      // R8 reserved encodings
      issue(enc(2, 1, zi(4, 0, 0, 0)), 32'd6, "R8");
      issue(enc(2, 1, zi(0, 4, 0, 0)), 32'd6, "R8");
      issue(enc(2, 1, zi(0, 0, 0, 0) | 11'h100), 32'd6, "R8");
      // R11 too small
      issue(enc(2, 0, zi(3, 5, 0, 0)), 32'd0, "R11");
      issue(enc(2, 1, zi(0, 5, 0, 0)), 32'hFFFF_FFFF, "R7");
      repeat (2) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #200000;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule